// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves 8-bit characters, least significant bit first, over one serial data output and one serial data input that share a single serial clock line. The transmit side and the receive side are separate units. Both are driven by the same clock edges, so a character can go out while another comes in.

The serial clock comes from one of two places. It can be made inside the block by dividing the system clock by a programmable value. In that case it is driven out on the clock pin, gives exactly eight pulses per character and rests high between characters. It can also be taken from an outside master through the clock pin. Those edges are brought into the system clock domain by a synchronizer before they are used.

Each direction has one holding byte in front of its shift register. The host can write the next character while the current one is shifting out. It can also read a finished character while the next one is arriving, so characters can run back to back with no gap.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the block drives `sck_o`=1, `sd_o`=1, `tx_empty`=1, `tx_done`=1, `rx_full`=0 and `rx_overrun`=0. With `clk_sel`=00 it also drives `sck_oe`=1.
- R2: A written byte leaves on `sd_o` as 8 bits, bit 0 first. A new bit appears on `sd_o` only in the system cycle that follows a serial clock falling edge. Each bit is valid at the following rising edge.
- R3: The receiver samples `sd_i` on each serial clock rising edge and shifts bits in LSB first. After the 8th rising edge of a character, the byte appears on `rx_rdata` and `rx_full` goes to 1. A one-cycle `rx_rd` pulse clears `rx_full`.
- R4: After the last bit of a character, `sd_o` keeps the value of bit 7 until the next character begins.
- R5: With `clk_sel[1]`=0 the serial clock is internal. Each low phase and each high phase lasts `div_val`+1 system cycles. A character has exactly 8 pulses, so the 8th rising edge comes 15×(`div_val`+1) cycles after the first falling edge. `sck_o` stays at 1 while no byte is pending.
- R6: `tx_empty` goes to 1 when the holding byte moves into the shift register. A `tx_wr` pulse clears it and is accepted only while `tx_empty`=1. A write made while `tx_empty`=0 has no effect.
- R7: `tx_done` goes to 1 at the 8th rising edge of a character if no byte is waiting in the holding byte at that time. An accepted write clears it.
- R8: If a byte is waiting when a character ends under the internal clock, the next character's first falling edge comes `div_val`+1 cycles after that 8th rising edge. Two back-to-back characters therefore take 31×(`div_val`+1) cycles from the first falling edge to the last rising edge.
- R9: If a character completes while `rx_full`=1, `rx_overrun` goes to 1 and `rx_rdata` keeps the older byte. A `rx_rd` pulse clears both flags.
- R10: With `clk_sel[1]`=1 the block drives `sck_oe`=0 and takes its clock edges from `sck_i`. It then sends and receives characters with the same bit order and the same flag behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 2 | Clock source select. Bit 1 = 0 selects the internal divider; bit 1 = 1 selects the external clock |
| div_val | input | 8 | Divider value N. The internal serial clock period is 2×(N+1) system cycles |
| tx_en | input | 1 | Enables the transmitter to start characters |
| rx_en | input | 1 | Enables the receiver. While low, the receiver's bit count is held at zero |
| tx_wr | input | 1 | One-cycle write strobe for the transmit holding byte |
| tx_wdata | input | 8 | Byte to transmit |
| rx_rd | input | 1 | One-cycle read strobe. Clears the receive-full and overrun flags |
| rx_rdata | output | 8 | Last byte received |
| tx_empty | output | 1 | Transmit holding byte is free |
| tx_done | output | 1 | Last character finished with nothing pending |
| rx_full | output | 1 | A received byte is waiting to be read |
| rx_overrun | output | 1 | A byte was lost because `rx_full` was still set |
| sck_o | output | 1 | Serial clock driven out in internal mode |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| sck_i | input | 1 | Serial clock from an external master |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
The bench goes after these corner cases:
- Seam between two back-to-back characters. A design that idles between them, or counts a ninth pulse, misses the 31×(N+1) span.
- Write made while the holding byte is still full. A design that accepts it sends the wrong second character.
- Second received character arriving while `rx_full` is set. A design that overwrites the buffer reports the newer byte.
- Line state after a character. A design that drops `sd_o` back to 1 shows up on bytes whose bit 7 is 0.
- External-clock run. A design that leaves the pin driven, or mis-times the synchronized data, shows wrong `sck_oe` or corrupted bytes.

// File: rtl/sync_xcvr_pkg.sv
// Package: shared clock-source encoding and helper for the serial transceiver.
// Assumes the clock select field is two bits wide, and that only its upper bit
// chooses between the internal divider and the external pin.
package sync_xcvr_pkg;

    typedef enum logic [1:0] {
        CKS_INT     = 2'b00,
        CKS_INT_ALT = 2'b01,
        CKS_EXT     = 2'b10,
        CKS_EXT_ALT = 2'b11
    } cks_sel_e;

    // True when the select field asks for the external clock pin.
    function automatic logic cks_is_ext(input logic [1:0] sel);
        return sel[1];
    endfunction

endpackage

// File: rtl/xcvr_pin_sync.sv
// Module: brings the external serial clock and serial data into the system
// clock domain. It delays both by the same number of flops and reports
// one-cycle rise and fall pulses of the synchronized clock.
// Assumes each external clock phase lasts several system cycles.
module xcvr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sd_i,
    output logic ext_fall,
    output logic ext_rise,
    output logic sd_s
);

    logic [STAGES:0]   sck_pipe;
    logic [STAGES-1:0] sd_pipe;

    // Shift the clock pin through STAGES+1 flops; the extra flop gives the edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '1;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-1:0], sck_i};
        end
    end

    // Delay the data pin by STAGES flops so it lines up with the synchronized clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_pipe <= '1;
        end else begin
            sd_pipe <= {sd_pipe[STAGES-2:0], sd_i};
        end
    end

    // Decode edges from the last two clock flops.
    always_comb begin
        ext_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
        ext_fall = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
        sd_s     = sd_pipe[STAGES-1];
    end

endmodule

// File: rtl/xcvr_clkgen.sv
// Module: internal serial clock generator. While idle it holds its clock high.
// When asked to start, it makes a falling edge at once and then toggles every
// DIV+1 system cycles. It stops after the DATA_W-th rising edge unless more
// work is pending at that edge. Each edge is reported as a one-cycle pulse.
// Assumes div_val is held stable while a character is in progress.
module xcvr_clkgen #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_en,
    input  logic             go,
    input  logic [DIV_W-1:0] div_val,
    output logic             sck_q,
    output logic             fall_ev,
    output logic             rise_ev
);

    localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic             run;
    logic [DIV_W-1:0] dcnt;
    logic [CW-1:0]    pcnt;

    // Run the half-period counter and toggle the clock; count pulses per character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            sck_q   <= 1'b1;
            dcnt    <= '0;
            pcnt    <= '0;
            fall_ev <= 1'b0;
            rise_ev <= 1'b0;
        end else begin
            fall_ev <= 1'b0;
            rise_ev <= 1'b0;
            if (!int_en) begin
                run   <= 1'b0;
                sck_q <= 1'b1;
                dcnt  <= '0;
                pcnt  <= '0;
            end else if (!run) begin
                sck_q <= 1'b1;
                if (go) begin
                    run     <= 1'b1;
                    sck_q   <= 1'b0;
                    fall_ev <= 1'b1;
                    dcnt    <= '0;
                    pcnt    <= '0;
                end
            end else if (dcnt == div_val) begin
                dcnt <= '0;
                if (!sck_q) begin
                    sck_q   <= 1'b1;
                    rise_ev <= 1'b1;
                    pcnt    <= pcnt + 1'b1;
                    if (pcnt == LAST && !go) begin
                        run <= 1'b0;
                    end
                end else begin
                    sck_q   <= 1'b0;
                    fall_ev <= 1'b1;
                end
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end

    // R5
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_ev && rise_ev));

    // R5
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en) |=> sck_q);

endmodule

// File: rtl/xcvr_tx.sv
// Module: transmitter. It has a holding byte and a shift register. The holding
// byte moves into the shift register on the falling edge that opens a
// character, and bit 0 is driven then. The other bits follow on later falling
// edges. The character closes on its DATA_W-th rising edge, and the line then
// keeps the last bit driven.
// Assumes fall_ev and rise_ev never pulse in the same cycle.
module xcvr_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fall_ev,
    input  logic              rise_ev,
    output logic              sd_q,
    output logic              tdre,
    output logic              tend
);

    localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [DATA_W-1:0] hold;
    logic [DATA_W-2:0] shreg;
    logic              active;
    logic [CW-1:0]     rcnt;

    // Load, shift and close characters on serial clock edges; accept host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= '0;
            shreg  <= '0;
            active <= 1'b0;
            rcnt   <= '0;
            sd_q   <= 1'b1;
            tdre   <= 1'b1;
            tend   <= 1'b1;
        end else begin
            if (fall_ev) begin
                if (active) begin
                    sd_q  <= shreg[0];
                    shreg <= shreg >> 1;
                end else if (en && !tdre) begin
                    sd_q   <= hold[0];
                    shreg  <= hold[DATA_W-1:1];
                    active <= 1'b1;
                    rcnt   <= '0;
                    tdre   <= 1'b1;
                end
            end
            if (rise_ev && active) begin
                rcnt <= rcnt + 1'b1;
                if (rcnt == LAST) begin
                    active <= 1'b0;
                    tend   <= tdre;
                end
            end
            if (wr && tdre) begin
                hold <= wdata;
                tdre <= 1'b0;
                tend <= 1'b0;
            end
        end
    end

    // R6
    tdre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tdre) |-> $past(wr));

    // R2
    sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall_ev) |-> $stable(sd_q));

    // R7
    tend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tend) |-> tdre);

endmodule

// File: rtl/xcvr_rx.sv
// Module: receiver. It shifts in one bit per serial rising edge, LSB first.
// After DATA_W bits the byte moves into the read buffer unless that buffer is
// still full; in that case the overrun flag is set and the old byte is kept.
// Assumes rise_ev pulses once per serial rising edge.
module xcvr_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rise_ev,
    input  logic              sd_bit,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              rdrf,
    output logic              ovr
);

    localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] next_byte;

    // Form the byte the current edge would complete.
    always_comb begin
        next_byte = {sd_bit, shreg[DATA_W-1:1]};
    end

    // Shift in bits, hand complete bytes to the buffer, and handle host reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            rdata <= '0;
            rdrf  <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (rd) begin
                rdrf <= 1'b0;
                ovr  <= 1'b0;
            end
            if (!en) begin
                cnt <= '0;
            end else if (rise_ev) begin
                shreg <= next_byte;
                cnt   <= cnt + 1'b1;
                if (cnt == LAST) begin
                    if (rdrf && !rd) begin
                        ovr <= 1'b1;
                    end else begin
                        rdata <= next_byte;
                        rdrf  <= 1'b1;
                    end
                end
            end
        end
    end

    // R3
    rdrf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdrf) |-> $past(rise_ev));

    // R9
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rdata));

endmodule

// File: rtl/sync_serial_xcvr.sv
// Module: top of the clocked synchronous serial transceiver. It chooses the
// serial clock edges from the internal generator or the synchronized pin and
// feeds them to the independent transmitter and receiver.
// Assumes clk_sel changes only while no character is in progress.
module sync_serial_xcvr
    import sync_xcvr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              tx_empty,
    output logic              tx_done,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              sd_o,
    input  logic              sd_i
);

    logic ext_mode;
    logic int_fall, int_rise;
    logic ext_fall, ext_rise;
    logic fall_ev, rise_ev;
    logic sd_s, sd_bit;
    logic go;

    // Pick the clock source and the data path that matches it.
    always_comb begin
        ext_mode = cks_is_ext(clk_sel);
        fall_ev  = ext_mode ? ext_fall : int_fall;
        rise_ev  = ext_mode ? ext_rise : int_rise;
        sd_bit   = ext_mode ? sd_s : sd_i;
        go       = tx_en & ~tx_empty;
        sck_oe   = ~ext_mode;
    end

    xcvr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .sd_i     (sd_i),
        .ext_fall (ext_fall),
        .ext_rise (ext_rise),
        .sd_s     (sd_s)
    );

    xcvr_clkgen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_en  (~ext_mode),
        .go      (go),
        .div_val (div_val),
        .sck_q   (sck_o),
        .fall_ev (int_fall),
        .rise_ev (int_rise)
    );

    xcvr_tx #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tx_en),
        .wr      (tx_wr),
        .wdata   (tx_wdata),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev),
        .sd_q    (sd_o),
        .tdre    (tx_empty),
        .tend    (tx_done)
    );

    xcvr_rx #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .rise_ev (rise_ev),
        .sd_bit  (sd_bit),
        .rd      (rx_rd),
        .rdata   (rx_rdata),
        .rdrf    (rx_full),
        .ovr     (rx_overrun)
    );

    // R10
    ext_pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> !sck_oe);

    // R5
    ev_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_ev, rise_ev}));

endmodule

// File: tb/sync_serial_xcvr_tb.sv
module sync_serial_xcvr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic [7:0] div_val = 8'd0;
    logic       tx_en = 1'b1;
    logic       rx_en = 1'b1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = 8'd0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_rdata;
    logic       tx_empty, tx_done, rx_full, rx_overrun;
    logic       sck_o, sck_oe;
    logic       sck_i = 1'b1;
    logic       sd_o;
    logic       sd_i = 1'b1;

    always #4 clk = ~clk;

    sync_serial_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_val(div_val),
        .tx_en(tx_en), .rx_en(rx_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_empty(tx_empty),
        .tx_done(tx_done), .rx_full(rx_full), .rx_overrun(rx_overrun),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .sd_o(sd_o), .sd_i(sd_i)
    );

    // {tx byte, byte sent by the peer, divider}
    localparam logic [23:0] VECS [6] = '{
        {8'hA5, 8'h3C, 8'd0}, {8'h01, 8'h80, 8'd1}, {8'h80, 8'h01, 8'd3},
        {8'hFF, 8'h00, 8'd7}, {8'h00, 8'hFF, 8'd2}, {8'h6D, 8'hB2, 8'd5}
    };

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int nfall, nrise, first_fall, last_rise;
    logic [15:0] cap;
    logic [15:0] peer_sr;
    logic line, line_prev = 1'b1;

    // Peer model: drive sd_i after falls, capture sd_o at rises.
    always @(negedge clk) begin
        cyc++;
        line = sck_oe ? sck_o : sck_i;
        if (line_prev === 1'b1 && line === 1'b0) begin
            nfall++;
            if (first_fall < 0) first_fall = cyc;
            sd_i = peer_sr[0];
            peer_sr = peer_sr >> 1;
        end
        if (line_prev === 1'b0 && line === 1'b1) begin
            nrise++;
            cap = {sd_o, cap[15:1]};
            last_rise = cyc;
        end
        line_prev = line;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mon_clear(input logic [15:0] peer);
        nfall = 0; nrise = 0; first_fall = -1; last_rise = 0;
        cap = '0; peer_sr = peer;
    endtask

    task automatic host_write(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000 && tx_done !== 1'b1; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog (all R): actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        mon_clear(16'hFFFF);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sck_o", sck_o, 1);
        chk("R1 sck_oe", sck_oe, 1);
        chk("R1 sd_o", sd_o, 1);
        chk("R1 flags", {tx_empty, tx_done, rx_full, rx_overrun}, 4'b1100);

        // R5 idle: nothing pending, clock stays high
        mon_clear(16'hFFFF);
        repeat (40) @(negedge clk);
        chk("R5 idle falls", nfall, 0);
        chk("R5 idle level", sck_o, 1);

        // Vector table: one character each direction, internal clock
        for (int v = 0; v < 6; v++) begin
            logic [7:0] tb, rb, dv;
            {tb, rb, dv} = VECS[v];
            div_val = dv;
            mon_clear({8'hFF, rb});
            host_write(tb);
            wait_done();
            chk("R2 tx byte", cap[15:8], tb);
            chk("R3 rx byte", rx_rdata, rb);
            chk("R3 rx_full", rx_full, 1);
            chk("R5 pulses", nrise * 100 + nfall, 808);
            chk("R5 span", last_rise - first_fall, 15 * (dv + 1));
            chk("R5 rest high", sck_o, 1);
            chk("R4 msb hold", sd_o, tb[7]);
            chk("R7 tx_done", tx_done, 1);
            host_read();
            chk("R3 read clears", rx_full, 0);
        end

        // R8 / R6 / R9: back-to-back characters, extra write, overrun
        div_val = 8'd2;
        mon_clear({8'h5A, 8'hC3});
        host_write(8'h96);
        for (int i = 0; i < 100 && tx_empty !== 1'b1; i++) @(negedge clk);
        host_write(8'h4B);
        chk("R6 empty cleared", tx_empty, 0);
        host_write(8'hE7);
        chk("R7 not done mid", tx_done, 0);
        wait_done();
        chk("R6 ignored write", cap, 16'h4B96);
        chk("R8 pulses", nrise, 16);
        chk("R8 span", last_rise - first_fall, 31 * 3);
        chk("R9 overrun", rx_overrun, 1);
        chk("R9 old byte kept", rx_rdata, 8'hC3);
        host_read();
        chk("R9 read clears", {rx_full, rx_overrun}, 2'b00);

        // R10 external clock
        clk_sel = 2'b10;
        repeat (4) @(negedge clk);
        chk("R10 pin released", sck_oe, 0);
        mon_clear({8'hFF, 8'h9D});
        host_write(8'h2E);
        repeat (4) @(negedge clk);
        for (int p = 0; p < 8; p++) begin
            sck_i = 1'b0; repeat (6) @(negedge clk);
            sck_i = 1'b1; repeat (6) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        chk("R10 tx byte", cap[15:8], 8'h2E);
        chk("R10 rx byte", rx_rdata, 8'h9D);
        chk("R10 flags", {rx_full, tx_done, tx_empty}, 3'b111);
        chk("R10 msb hold", sd_o, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule